// File: doc/BRIEF.md
# Multiplexed Parallel Host Register Port

This block lets a microcontroller reach a small internal register file over one 8-bit bidirectional bus that carries both register addresses and data bytes. Three host strobes qualify each clock edge: an active-low select, a read/write line (high means the host reads), and an address/data line (high means the bus byte is a register address). The port keeps the last address it was given. Data cycles then read from or write to the register at that address. The port also produces the output enable that a pad ring uses to turn the shared bus pins around.

The example register map covers the status and override needs of a video error-checking datapath. It has a read-only view of the error flags and a read-only view of the standard that was detected automatically. It has writable registers for an override value for those flags, a mask that chooses which flags are overridden, and a standard-override control byte. The writable registers leave the block on dedicated outputs so that the datapath can apply them before retransmission.

Top module: `hostPort`

## Requirements
- R1: While the active-low reset `rstN` is low, the address latch and every writable register are cleared to 0x00. A data read made after reset with no address cycle therefore returns the register at address 0x00.
- R2: On each clock edge where `csN` is low, `addrSel` is high and `rdWr` is low, the address latch takes the bus byte. The latch keeps that value across later select assertions until the next address cycle.
- R3: While `csN` is low and `rdWr` is high, `busOe` is high and `busOut` carries the contents of the latched address in the same cycle.
- R4: While `csN` is high, `busOe` is low.
- R5: On a clock edge where `csN` is low, `addrSel` is low and `rdWr` is low, the bus byte is written into the writable register at the latched address. The new value shows on that register's output port and in reads from the next cycle onward.
- R6: Each assertion of `csN` allows at most one write. Later data-write edges inside the same low period of `csN` leave every register unchanged, until `csN` has been high for at least one edge.
- R7: A read of an address outside 0x00..0x04 returns 0x00.
- R8: Writes to the read-only addresses 0x00 and 0x04, or to unmapped addresses, change no register. Reads and output ports afterwards show the previous values.
- R9: Register map. 0x00 reads `errFlagsIn` (read-only). 0x01 is the flag override value (`ovrValue`). 0x02 is the flag override mask (`ovrMask`). 0x03 is the standard override control (`stdCtrl`). 0x04 reads `{4'b0000, stdDetIn}` (read-only).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Active-low select from the host |
| rdWr | input | 1 | 1 = host reads, 0 = host writes |
| addrSel | input | 1 | 1 = bus carries an address, 0 = bus carries data |
| busIn | input | 8 | Bus value driven by the host |
| busOut | output | 8 | Read data for the bus pads |
| busOe | output | 1 | Pad output enable; low leaves the bus high impedance |
| errFlagsIn | input | 8 | Live error flags, read at 0x00 |
| stdDetIn | input | 4 | Automatically detected standard code, read at 0x04 |
| ovrValue | output | 8 | Flag override value register (0x01) |
| ovrMask | output | 8 | Flag override mask register (0x02) |
| stdCtrl | output | 8 | Standard override control register (0x03) |

## Verification
In one select period the host can write a register on one edge and flip `rdWr` high on the next. The register update and the combinational read path then meet in adjacent cycles, and the read must already show the new byte. The bench provokes this without releasing `csN` and compares the byte on `busOut` with the value just written. The other collision is a second data-write edge that falls inside the same select as the first. The bench presents a different byte on that edge and judges it through the register's output port and a later read, both of which must still hold the first byte.

// File: rtl/hostport_pkg.sv
package hostport_pkg;
  // Strobes from the bus-cycle decoder to the register datapath
  typedef struct packed {
    logic loadAddr;  // take bus byte into the address latch
    logic doWrite;   // write bus byte into the addressed register
    logic driveBus;  // host is reading: enable the pads
  } ctrlStrobes_t;
endpackage

// File: rtl/hostPortCtrl.sv
module hostPortCtrl
  import hostport_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         csN,
  input  logic         rdWr,
  input  logic         addrSel,
  output ctrlStrobes_t strobes
);
  // Set once a write has happened in the current select period
  logic wrDone;

  always_comb begin
    strobes.loadAddr = !csN && addrSel && !rdWr;
    strobes.doWrite  = !csN && !addrSel && !rdWr && !wrDone;
    strobes.driveBus = !csN && rdWr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        wrDone <= 1'b0;
    else if (csN)     wrDone <= 1'b0;
    else if (strobes.doWrite) wrDone <= 1'b1;
  end
endmodule

// File: rtl/hostPortRegs.sv
module hostPortRegs
  import hostport_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int STD_W     = 4,
  parameter int NUM_RW    = 3,
  parameter int STAT_ADDR = 0,
  parameter int RW_BASE   = 1,
  parameter int DET_ADDR  = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  ctrlStrobes_t             strobes,
  input  logic [DATA_W-1:0]        busIn,
  input  logic [DATA_W-1:0]        statusIn,
  input  logic [STD_W-1:0]         detIn,
  output logic [DATA_W-1:0]        rdData,
  output logic [NUM_RW*DATA_W-1:0] rwFlat
);
  localparam logic [DATA_W-1:0] STAT_A = DATA_W'(STAT_ADDR);
  localparam logic [DATA_W-1:0] DET_A  = DATA_W'(DET_ADDR);
  localparam int PAD_W = DATA_W - STD_W;

  logic [DATA_W-1:0] addrQ;
  logic [DATA_W-1:0] rwReg [NUM_RW];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 addrQ <= '0;
    else if (strobes.loadAddr) addrQ <= busIn;
  end

  for (genvar i = 0; i < NUM_RW; i++) begin : g_rw
    localparam logic [DATA_W-1:0] MY_A = DATA_W'(RW_BASE + i);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                rwReg[i] <= '0;
      else if (strobes.doWrite && addrQ == MY_A) rwReg[i] <= busIn;
    end
    assign rwFlat[i*DATA_W +: DATA_W] = rwReg[i];
  end

  always_comb begin
    rdData = '0;
    if (addrQ == STAT_A) rdData = statusIn;
    if (addrQ == DET_A)  rdData = {{PAD_W{1'b0}}, detIn};
    for (int i = 0; i < NUM_RW; i++) begin
      if (addrQ == DATA_W'(RW_BASE + i)) rdData = rwReg[i];
    end
  end
endmodule

// File: rtl/hostPort.sv
module hostPort
  import hostport_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int STD_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              rdWr,
  input  logic              addrSel,
  input  logic [DATA_W-1:0] busIn,
  output logic [DATA_W-1:0] busOut,
  output logic              busOe,
  input  logic [DATA_W-1:0] errFlagsIn,
  input  logic [STD_W-1:0]  stdDetIn,
  output logic [DATA_W-1:0] ovrValue,
  output logic [DATA_W-1:0] ovrMask,
  output logic [DATA_W-1:0] stdCtrl
);
  localparam int NUM_RW = 3;

  ctrlStrobes_t             strobes;
  logic [NUM_RW*DATA_W-1:0] rwFlat;

  hostPortCtrl ctrl_i (
    .clk(clk), .rstN(rstN), .csN(csN), .rdWr(rdWr),
    .addrSel(addrSel), .strobes(strobes)
  );

  hostPortRegs #(
    .DATA_W(DATA_W), .STD_W(STD_W), .NUM_RW(NUM_RW),
    .STAT_ADDR(0), .RW_BASE(1), .DET_ADDR(4)
  ) regs_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .busIn(busIn),
    .statusIn(errFlagsIn), .detIn(stdDetIn),
    .rdData(busOut), .rwFlat(rwFlat)
  );

  assign busOe    = strobes.driveBus;
  assign ovrValue = rwFlat[0*DATA_W +: DATA_W];
  assign ovrMask  = rwFlat[1*DATA_W +: DATA_W];
  assign stdCtrl  = rwFlat[2*DATA_W +: DATA_W];
endmodule

// File: rtl/hostPortChk.sv
module hostPortChk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              csN,
  input logic              rdWr,
  input logic              addrSel,
  input logic              busOe,
  input logic [DATA_W-1:0] ovrValue,
  input logic [DATA_W-1:0] ovrMask,
  input logic [DATA_W-1:0] stdCtrl
);
  logic wrEdge;
  assign wrEdge = !csN && !addrSel && !rdWr;

  assert_oe_off_R4: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !busOe);

  assert_oe_on_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && rdWr) |-> busOe);

  assert_one_write_R6: assert property (@(posedge clk) disable iff (!rstN)
    (wrEdge && $past(wrEdge)) |=> ($stable(ovrValue) && $stable(ovrMask) && $stable(stdCtrl)));

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rstN |-> (ovrValue == '0 && ovrMask == '0 && stdCtrl == '0));
endmodule

bind hostPort hostPortChk #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rstN(rstN), .csN(csN), .rdWr(rdWr), .addrSel(addrSel),
  .busOe(busOe), .ovrValue(ovrValue), .ovrMask(ovrMask), .stdCtrl(stdCtrl)
);

// File: tb/hostPort_tb_top.sv
module hostPort_tb_top;
  logic       clk = 1'b0;
  logic       rstN, csN, rdWr, addrSel;
  logic [7:0] busIn, busOut, errFlagsIn, ovrValue, ovrMask, stdCtrl;
  logic [3:0] stdDetIn;
  logic       busOe;
  int nChecks = 0;
  int nErrors = 0;

  always #2 clk = ~clk;  // 250 MHz

  hostPort dut_i (
    .clk(clk), .rstN(rstN), .csN(csN), .rdWr(rdWr), .addrSel(addrSel),
    .busIn(busIn), .busOut(busOut), .busOe(busOe),
    .errFlagsIn(errFlagsIn), .stdDetIn(stdDetIn),
    .ovrValue(ovrValue), .ovrMask(ovrMask), .stdCtrl(stdCtrl)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    csN = 1'b1; rdWr = 1'b0; addrSel = 1'b0; busIn = 8'h00;
  endtask

  task automatic busAddr(logic [7:0] a);
    @(negedge clk);
    csN = 1'b0; rdWr = 1'b0; addrSel = 1'b1; busIn = a;
    idle();
  endtask

  task automatic busWrite(logic [7:0] d);
    @(negedge clk);
    csN = 1'b0; rdWr = 1'b0; addrSel = 1'b0; busIn = d;
    idle();
  endtask

  task automatic busRead(string req, logic [7:0] exp);
    @(negedge clk);
    csN = 1'b0; rdWr = 1'b1; addrSel = 1'b0; busIn = 8'h00;
    #1;
    check({req, " oe"}, {7'd0, busOe}, 8'h01);
    check(req, busOut, exp);
    idle();
  endtask

  task automatic testReset();
    rstN = 1'b0; csN = 1'b1; rdWr = 1'b0; addrSel = 1'b0; busIn = 8'h00;
    errFlagsIn = 8'hA5; stdDetIn = 4'h6;
    repeat (3) @(negedge clk);
    check("R1 ovrValue", ovrValue, 8'h00);
    check("R1 ovrMask", ovrMask, 8'h00);
    check("R1 stdCtrl", stdCtrl, 8'h00);
    check("R4 oe in reset", {7'd0, busOe}, 8'h00);
    rstN = 1'b1;
    busRead("R1 latch cleared reads 0x00", 8'hA5);
  endtask

  task automatic testWriteRead();
    busAddr(8'h01); busWrite(8'h3C);
    check("R5 ovrValue port", ovrValue, 8'h3C);
    busAddr(8'h02); busWrite(8'hF0);
    check("R5 ovrMask port", ovrMask, 8'hF0);
    busAddr(8'h03); busWrite(8'h87);
    check("R9 stdCtrl port", stdCtrl, 8'h87);
    busRead("R9 read 0x03", 8'h87);
    busAddr(8'h01); busRead("R9 read 0x01", 8'h3C);
    busAddr(8'h02); busRead("R9 read 0x02", 8'hF0);
  endtask

  task automatic testStatus();
    busAddr(8'h00); busRead("R9 flags", 8'hA5);
    errFlagsIn = 8'h5B;
    busRead("R9 flags live", 8'h5B);
    busAddr(8'h04); busRead("R9 detected std", 8'h06);
    stdDetIn = 4'hD;
    busRead("R9 detected std live", 8'h0D);
  endtask

  task automatic testAddrHold();
    busAddr(8'h02);
    busRead("R2 first read", 8'hF0);
    repeat (3) idle();
    busRead("R2 latch kept", 8'hF0);
  endtask

  task automatic testUnmapped();
    busAddr(8'h05); busRead("R7 read 0x05", 8'h00);
    busAddr(8'hFF); busRead("R7 read 0xFF", 8'h00);
    busWrite(8'h77);
    check("R8 unmapped ovrValue", ovrValue, 8'h3C);
    check("R8 unmapped ovrMask", ovrMask, 8'hF0);
    check("R8 unmapped stdCtrl", stdCtrl, 8'h87);
    busRead("R8 unmapped still 0", 8'h00);
  endtask

  task automatic testReadOnly();
    busAddr(8'h00); busWrite(8'h11);
    busRead("R8 write 0x00 ignored", 8'h5B);
    busAddr(8'h04); busWrite(8'h22);
    busRead("R8 write 0x04 ignored", 8'h0D);
    check("R8 ro ovrValue", ovrValue, 8'h3C);
    check("R8 ro stdCtrl", stdCtrl, 8'h87);
  endtask

  task automatic testWriteOnce();
    busAddr(8'h01);
    @(negedge clk);
    csN = 1'b0; rdWr = 1'b0; addrSel = 1'b0; busIn = 8'h96;
    @(negedge clk);
    busIn = 8'h69;  // second write edge, same select
    @(negedge clk);
    check("R6 port after second edge", ovrValue, 8'h96);
    rdWr = 1'b1;    // turn around inside the same select
    #1;
    check("R3 read right after write", busOut, 8'h96);
    check("R3 oe", {7'd0, busOe}, 8'h01);
    idle();
    busWrite(8'h42);
    check("R6 rearmed after release", ovrValue, 8'h42);
  endtask

  task automatic testHighZ();
    idle();
    #1;
    check("R4 oe released", {7'd0, busOe}, 8'h00);
    @(negedge clk);
    csN = 1'b0; rdWr = 1'b0; addrSel = 1'b0; busIn = 8'h00;
    #1;
    check("R4 host write no drive", {7'd0, busOe}, 8'h00);
    csN = 1'b1;
    idle();
  endtask

  initial begin
    testReset();
    testWriteRead();
    testStatus();
    testAddrHold();
    testUnmapped();
    testReadOnly();
    testWriteOnce();
    testHighZ();
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

  initial begin
    #400000;
    nChecks++;
    nErrors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end
endmodule